// File: doc/BRIEF.md
# ADC offset and gain calibration controller

This block trims an external 14-bit converter automatically by driving two signed correction codes: one for the DAC that shifts the converter's zero point and one for the DAC that fine-tunes its gain. A calibration runs in two fixed phases. In the first phase the system applies a dark (zero-signal) stimulus, and the block moves the offset code until the converted dark level sits exactly at code 0 with its least significant bit flickering. In the second phase the system applies a saturated stimulus, and the block moves the gain code until the converted level sits at full scale (0x3FFF) with its least significant bit flickering. Gain is touched only after offset has converged, so the two adjustments do not disturb each other.

Each trial judges a window of accepted samples by how often the least significant bit is set and by whether any sample lies outside the two-code target band. The verdict steers a successive-approximation search over the code range, and a few single-code refinement steps follow. The phase output tells the stimulus source which level to present. When the code needed lies beyond the trim span, the block reports a failure and holds the codes it reached.

Top module: `cal_ctrl`

## Requirements
- R1: After reset both codes are 0, busy, done and fail are low, and the phase output is 0.
- R2: A start pulse while idle, done or failed clears done and fail, sets both codes to 0, raises busy and enters the offset phase. A start pulse during a calibration has no effect.
- R3: After every code change (and after start or a phase change) the next SETTLE sample cycles are skipped. Each trial then uses the next N valid samples, with defaults SETTLE=4 and N=16.
- R4: In the offset phase a trial is too high if any sample exceeds 1 or more than 3N/4 samples have bit 0 set. It is too low if fewer than N/4 samples have bit 0 set. Otherwise the target is met.
- R5: In the gain phase a trial is too low if any sample is below 0x3FFE or fewer than N/4 samples have bit 0 set. It is too high if more than 3N/4 samples have bit 0 set. Otherwise the target is met.
- R6: Codes are 9-bit two's complement, from -256 to 255, and start at 0. A too-low verdict raises the code and a too-high verdict lowers it. Steps are 128, 64, ..., 1, and later steps are single codes.
- R7: If a single step would pass -256 or 255, or if MAXR (default 8) single steps pass without meeting the target, fail rises, busy falls and both codes hold.
- R8: The gain code stays unchanged until the offset target is met. The phase output is 0 during the offset phase and 1 during the gain phase.
- R9: When the gain target is met, done rises, busy falls, and both codes hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_start | input | 1 | Start pulse for a calibration |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Straight-binary converter sample |
| ofs_code | output | 9 | Signed offset correction code |
| gain_code | output | 9 | Signed fine-gain correction code |
| cal_phase | output | 1 | 0: present dark level, 1: present saturated level |
| cal_busy | output | 1 | Calibration in progress |
| cal_done | output | 1 | Both targets met |
| cal_fail | output | 1 | A target could not be met within the span |

## Verification
The assertions assume that the stimulus source follows the phase output and that each sample depends only on the codes currently driven. Under that assumption a code can change only after a full window, a single-step search moves by at most one code, and the gain code cannot move before the phase changes. They also assume SETTLE is at least 2, so samples taken while a new code settles are never counted. The bench meets these assumptions with a converter model that recomputes every sample from the live codes after each falling edge. The model adds a one-code dither that alternates every sample and clips to the 14-bit range, so each raw offset and gain error has exactly one code that meets the target.

// File: rtl/cal_pkg.sv
package cal_pkg;
  typedef enum logic [1:0] {V_MET, V_LOW, V_HIGH} verdict_t;
  typedef enum logic [1:0] {S_IDLE, S_OFS, S_GAIN, S_END} state_t;
endpackage

// File: rtl/cal_window.sv
module cal_window
  import cal_pkg::*;
#(
  parameter int DW     = 14,
  parameter int N      = 16,
  parameter int SETTLE = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          en,
  input  logic          tgt_full,
  input  logic          smp_valid,
  input  logic [DW-1:0] smp_data,
  output logic          eval_o,
  output verdict_t      verdict_o
);
  localparam int CNTW = $clog2(N + 1);
  localparam int BW   = $clog2(SETTLE + 1);
  localparam logic [CNTW-1:0] LAST   = CNTW'(N - 1);
  localparam logic [CNTW-1:0] LO_LIM = CNTW'(N / 4);
  localparam logic [CNTW-1:0] HI_LIM = CNTW'((3 * N) / 4);
  localparam logic [BW-1:0]   BLANK0 = BW'(SETTLE);
  localparam logic [DW-1:0]   NEAR_FULL = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0]   ONE = DW'(1);

  logic [CNTW-1:0] cnt_q, ones_q, ones_n;
  logic [BW-1:0]   blank_q;
  logic            off_q, off_n, beyond, take, last;
  verdict_t        v_n;

  always_comb begin
    take   = en && smp_valid && (blank_q == '0) && !clr;
    last   = take && (cnt_q == LAST);
    ones_n = ones_q + {{(CNTW-1){1'b0}}, smp_data[0]};
    beyond = tgt_full ? (smp_data < NEAR_FULL) : (smp_data > ONE);
    off_n  = off_q || beyond;
    if (tgt_full) begin
      if (off_n || ones_n < LO_LIM)  v_n = V_LOW;
      else if (ones_n > HI_LIM)      v_n = V_HIGH;
      else                           v_n = V_MET;
    end else begin
      if (off_n || ones_n > HI_LIM)  v_n = V_HIGH;
      else if (ones_n < LO_LIM)      v_n = V_LOW;
      else                           v_n = V_MET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      ones_q    <= '0;
      off_q     <= 1'b0;
      blank_q   <= '0;
      eval_o    <= 1'b0;
      verdict_o <= V_MET;
    end else if (clr) begin
      cnt_q   <= '0;
      ones_q  <= '0;
      off_q   <= 1'b0;
      blank_q <= BLANK0;
      eval_o  <= 1'b0;
    end else begin
      eval_o <= last;
      if (last) begin
        cnt_q     <= '0;
        ones_q    <= '0;
        off_q     <= 1'b0;
        blank_q   <= BLANK0;
        verdict_o <= v_n;
      end else if (take) begin
        cnt_q  <= cnt_q + 1'b1;
        ones_q <= ones_n;
        off_q  <= off_n;
      end else if (blank_q != '0) begin
        blank_q <= blank_q - 1'b1;
      end
    end
  end

  // R3: two trials never end on adjacent cycles
  a_r3_eval_gap: assert property (@(posedge clk) disable iff (rst)
    eval_o |=> !eval_o);
  // R3: no sample is counted while settling
  a_r3_blank_skip: assert property (@(posedge clk) disable iff (rst)
    (blank_q != '0 && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/cal_search.sv
module cal_search
  import cal_pkg::*;
#(
  parameter int CW   = 9,
  parameter int MAXR = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 init,
  input  logic                 en,
  input  logic                 eval,
  input  verdict_t             verdict,
  output logic signed [CW-1:0] code_o,
  output logic                 done_o,
  output logic                 fail_o
);
  localparam int RW = $clog2(MAXR + 1);
  localparam logic [CW-1:0] MID   = {1'b1, {(CW-1){1'b0}}};
  localparam logic [CW-1:0] STEP0 = {2'b01, {(CW-2){1'b0}}};
  localparam logic [CW-1:0] UMAX  = {CW{1'b1}};
  localparam logic [RW-1:0] RLIM  = RW'(MAXR);

  logic [CW-1:0] u_q, step_q;
  logic [RW-1:0] rc_q;
  logic          act;

  assign act    = en && eval && !done_o && !fail_o;
  assign code_o = signed'(u_q ^ MID);

  always_ff @(posedge clk) begin
    if (rst || init) begin
      u_q    <= MID;
      step_q <= STEP0;
      rc_q   <= '0;
      done_o <= 1'b0;
      fail_o <= 1'b0;
    end else if (act) begin
      case (verdict)
        V_MET: done_o <= 1'b1;
        V_LOW: begin
          if (step_q != '0) begin
            u_q    <= u_q + step_q;
            step_q <= step_q >> 1;
          end else if (u_q == UMAX || rc_q == RLIM) begin
            fail_o <= 1'b1;
          end else begin
            u_q  <= u_q + 1'b1;
            rc_q <= rc_q + 1'b1;
          end
        end
        default: begin
          if (step_q != '0) begin
            u_q    <= u_q - step_q;
            step_q <= step_q >> 1;
          end else if (u_q == '0 || rc_q == RLIM) begin
            fail_o <= 1'b1;
          end else begin
            u_q  <= u_q - 1'b1;
            rc_q <= rc_q + 1'b1;
          end
        end
      endcase
    end
  end

  // R6: refinement moves the code by at most one
  a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
    (step_q == '0 && !init) |=>
      (u_q == $past(u_q) || u_q == $past(u_q) + 1'b1 || u_q == $past(u_q) - 1'b1));
  // R7: failure only at a span limit or with the refinement budget spent
  a_r7_fail_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_o) |-> (u_q == '0 || u_q == UMAX || rc_q == RLIM));
  // R9: a finished search holds its code
  a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
    ((done_o || fail_o) && !init) |=> $stable(u_q));
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
#(
  parameter int DW     = 14,
  parameter int N      = 16,
  parameter int SETTLE = 4,
  parameter int CW     = 9,
  parameter int MAXR   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cal_start,
  input  logic                 smp_valid,
  input  logic [DW-1:0]        smp_data,
  output logic signed [CW-1:0] ofs_code,
  output logic signed [CW-1:0] gain_code,
  output logic                 cal_phase,
  output logic                 cal_busy,
  output logic                 cal_done,
  output logic                 cal_fail
);
  state_t   state_q;
  logic     go, to_gain, clr, eval;
  verdict_t verdict;
  logic [1:0] s_done, s_fail;
  logic signed [CW-1:0] s_code [2];

  assign go      = cal_start && (state_q == S_IDLE || state_q == S_END);
  assign to_gain = (state_q == S_OFS) && s_done[0];
  assign clr     = go || to_gain;

  cal_window #(.DW(DW), .N(N), .SETTLE(SETTLE)) u_win (
    .clk(clk), .rst(rst), .clr(clr),
    .en(state_q == S_OFS || state_q == S_GAIN),
    .tgt_full(state_q == S_GAIN),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .eval_o(eval), .verdict_o(verdict)
  );

  for (genvar i = 0; i < 2; i++) begin : g_trim
    localparam state_t OWN_ST = (i == 0) ? S_OFS : S_GAIN;
    cal_search #(.CW(CW), .MAXR(MAXR)) u_srch (
      .clk(clk), .rst(rst), .init(go), .en(state_q == OWN_ST),
      .eval(eval), .verdict(verdict),
      .code_o(s_code[i]), .done_o(s_done[i]), .fail_o(s_fail[i])
    );
  end

  assign ofs_code  = s_code[0];
  assign gain_code = s_code[1];
  assign cal_phase = (state_q == S_GAIN);
  assign cal_busy  = (state_q == S_OFS) || (state_q == S_GAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      cal_done <= 1'b0;
      cal_fail <= 1'b0;
    end else if (go) begin
      state_q  <= S_OFS;
      cal_done <= 1'b0;
      cal_fail <= 1'b0;
    end else begin
      case (state_q)
        S_OFS:
          if (s_fail[0]) begin
            state_q  <= S_END;
            cal_fail <= 1'b1;
          end else if (s_done[0]) begin
            state_q <= S_GAIN;
          end
        S_GAIN:
          if (s_fail[1]) begin
            state_q  <= S_END;
            cal_fail <= 1'b1;
          end else if (s_done[1]) begin
            state_q  <= S_END;
            cal_done <= 1'b1;
          end
        default: ;
      endcase
    end
  end

  // R8: gain code frozen outside the gain phase
  a_r8_gain_frozen: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_GAIN && !go) |=> $stable(gain_code));
  // R8: gain phase is entered only from a met offset phase
  a_r8_order: assert property (@(posedge clk) disable iff (rst)
    $rose(cal_phase) |-> $past(s_done[0]));
  // R9: done and fail never together
  a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
    cal_done |-> !cal_fail);
  // R2: start during a run is ignored
  a_r2_busy_start: assert property (@(posedge clk) disable iff (rst)
    (cal_busy && cal_start) |=> !(cal_busy && ofs_code == '0 && $past(ofs_code) != '0));
endmodule

// File: tb/tb_cal_ctrl.sv
module tb_cal_ctrl;
  localparam int DW = 14;
  localparam int CW = 9;
  localparam int FS = 16383;
  // raw offset, raw gain level, expect fail, expected ofs, expected gain
  localparam int VEC [7][5] = '{
    '{   0, 16382, 0,    0,    0},
    '{  37, 16282, 0,  -37,  100},
    '{-120, 16382, 0,  120,    0},
    '{ 256, 16127, 0, -256,  255},
    '{-255, 16638, 0,  255, -256},
    '{ 300, 16382, 1, -256,    0},
    '{   0, 16082, 1,    0,  255}
  };

  logic clk = 1'b0, rst = 1'b1, cal_start = 1'b0, smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic signed [CW-1:0] ofs_code, gain_code;
  logic cal_phase, cal_busy, cal_done, cal_fail;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ofs_raw = 0, gain_raw = 16382;
  bit dith = 1'b0, gain_moved = 1'b0;

  always #2 clk = ~clk;

  cal_ctrl dut (
    .clk(clk), .rst(rst), .cal_start(cal_start), .smp_valid(smp_valid),
    .smp_data(smp_data), .ofs_code(ofs_code), .gain_code(gain_code),
    .cal_phase(cal_phase), .cal_busy(cal_busy), .cal_done(cal_done),
    .cal_fail(cal_fail)
  );

  // converter model: sample from live codes plus alternating one-code dither
  initial begin
    forever begin
      @(negedge clk);
      begin
        int v;
        dith = ~dith;
        if (!cal_phase) v = ofs_raw + int'(ofs_code) + int'(dith);
        else            v = gain_raw + int'(gain_code) + int'(dith);
        if (v < 0) v = 0;
        if (v > FS) v = FS;
        smp_data = DW'(v);
      end
      if (cal_busy && !cal_phase && gain_code != 0) gain_moved = 1'b1;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected under 150000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); cal_start = 1'b1;
    @(negedge clk); cal_start = 1'b0;
  endtask

  task automatic wait_end();
    for (int k = 0; k < 6000; k++) begin
      if (cal_done || cal_fail) break;
      @(negedge clk);
    end
  endtask

  initial begin
    smp_valid = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(ofs_code == 0,  "R1 ofs_code",  int'(ofs_code), 0);
    check(gain_code == 0, "R1 gain_code", int'(gain_code), 0);
    check(!cal_busy,      "R1 busy", int'(cal_busy), 0);
    check(!cal_done,      "R1 done", int'(cal_done), 0);
    check(!cal_fail,      "R1 fail", int'(cal_fail), 0);
    check(!cal_phase,     "R1 phase", int'(cal_phase), 0);

    // R4 R5 R6 R7 R9 vector table
    for (int i = 0; i < 7; i++) begin
      ofs_raw = VEC[i][0]; gain_raw = VEC[i][1];
      pulse_start();
      wait_end();
      check(cal_fail == VEC[i][2][0] && cal_done == !VEC[i][2][0],
            VEC[i][2] != 0 ? "R7 fail status" : "R9 done status",
            int'(cal_fail), VEC[i][2]);
      check(int'(ofs_code) == VEC[i][3], "R4 R6 offset code", int'(ofs_code), VEC[i][3]);
      check(int'(gain_code) == VEC[i][4], "R5 R6 gain code", int'(gain_code), VEC[i][4]);
    end

    // R9 codes hold after done
    ofs_raw = 37; gain_raw = 16282;
    pulse_start(); wait_end();
    repeat (60) @(negedge clk);
    check(cal_done && !cal_busy, "R9 done held", int'(cal_done), 1);
    check(ofs_code == -37 && gain_code == 100, "R9 codes held", int'(ofs_code), -37);

    // R2 restart after done clears status and codes
    ofs_raw = 0; gain_raw = 16382;
    pulse_start();
    check(!cal_done && cal_busy, "R2 restart status", int'(cal_done), 0);
    check(ofs_code == 0 && gain_code == 0, "R2 restart codes", int'(gain_code), 0);
    // R3 window timing: start edge + SETTLE skipped + N samples + 2 register stages
    begin
      int k = 1;
      while (!cal_phase && k < 200) begin
        @(negedge clk); k++;
      end
      check(k == 23, "R3 R8 cycles to gain phase", k, 23);
    end
    wait_end();

    // R2 start during a run is ignored
    ofs_raw = 200; gain_raw = 16382;
    pulse_start();
    while (ofs_code == 0) @(negedge clk);
    cal_start = 1'b1; @(negedge clk); cal_start = 1'b0;
    check(cal_busy && ofs_code != 0, "R2 start ignored while busy", int'(ofs_code), -200);
    wait_end();
    check(cal_done && ofs_code == -200, "R2 run completes", int'(ofs_code), -200);

    // R8 gain never moved during offset phase
    check(!gain_moved, "R8 gain frozen in offset phase", int'(gain_moved), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule